// File: doc/BRIEF.md
# Multi-Thread Reservation Monitor

This block keeps the reservation state behind locked-load / conditional-store pairs for a small group of hardware threads that share one memory. Each thread has its own request port, carrying a one-cycle valid pulse, an operation code, a physical address and an uncacheable flag. In the same cycle as a request, the block answers each conditional store with a result code and tells memory whether the store may be written.

Each thread holds a small two-state machine. RSV_IDLE means the thread has no reservation. RSV_HELD means it has one, with the reserved address kept beside the state. The transitions are:
- LOCK: a locked load moves the thread from either state to RSV_HELD and records the address.
- SNOOP: any store that reaches memory moves every thread whose reserved 16-byte granule it hits to RSV_IDLE.
- SC_MISS: a failing conditional store moves the issuing thread to RSV_IDLE.
- RESET: reset moves every thread to RSV_IDLE.

Requests that arrive together are resolved in order of rising thread index. Each thread also counts its consecutive conditional-store failures, and raises an alert pulse at every multiple of a set period.

Top module: `rsv_monitor`

## Requirements
- R1: A locked load (op code 1) takes the thread into RSV_HELD with the load address reserved, so a later cacheable conditional store (op code 3) from that thread to the same granule passes.
- R2: Addresses are matched on granules of 2^GRAN_LSB bytes (16 by default). A store that differs from the reserved address only in the low GRAN_LSB bits matches. A store that differs in any higher bit does not match.
- R3: A cacheable conditional store from a thread in RSV_IDLE, or to another granule, fails. It returns result 0, keeps mem_we low and moves the thread to RSV_IDLE, so a retry to the reserved granule also fails.
- R4: A cacheable conditional store that matches passes. It returns result 1 with mem_we high in the same cycle. The write then clears the thread's own reservation, so a second conditional store fails.
- R5: A conditional store with the uncacheable flag set skips the check. It returns result 2 with mem_we high whatever the reservation state. Result code 3 never appears.
- R6: Every store that reaches memory (a plain store with op code 2, a passing conditional store, or an uncacheable conditional store) clears the reservation of every thread whose granule it hits. A failing conditional store clears no other thread's reservation.
- R7: A plain load (op code 0) returns result 0 with mem_we low and leaves every reservation as it was. A plain store returns result 0 with mem_we high.
- R8: Requests in the same cycle are applied in order of rising thread index. Each request sees the reservation changes made by the lower-indexed requests of that cycle.
- R9: Every failing conditional store increments the issuing thread's 32-bit wrapping failure count. A passing or uncacheable conditional store resets that count to zero. When an increment brings the count to a multiple of ALERT_PERIOD, fail_alert bit t is high for exactly the following cycle.
- R10: Reset puts every thread in RSV_IDLE, clears every failure count and holds fail_alert low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | NUM_THR | Per-thread request valid, a one-cycle pulse |
| req_op | input | 2*NUM_THR | Per-thread op code: 0 load, 1 locked load, 2 store, 3 conditional store |
| req_addr | input | ADDR_W*NUM_THR | Per-thread physical address |
| req_unc | input | NUM_THR | Per-thread uncacheable flag |
| sc_result | output | 2*NUM_THR | Per-thread result: 0 fail, 1 pass, 2 uncacheable; 0 for other ops |
| mem_we | output | NUM_THR | Per-thread permission for memory to perform the store |
| fail_alert | output | NUM_THR | Per-thread one-cycle pulse at each multiple of ALERT_PERIOD failures |

## Verification
The bench targets the granule edge. It places a matching store 4 bytes into the reserved block and a missing one exactly 16 bytes away, which catches a design that compares every address bit or too few of them. It checks that snooping is not too broad: a failing conditional store from another thread must leave a peer's reservation in place. It also checks that snooping is not too narrow: plain stores, passing conditional stores and uncacheable conditional stores must each clear every matching reservation. Same-cycle pairs in both orders expose a design that evaluates all threads against the old state instead of in index order. The alert sequence runs to the period, is reset by an uncacheable store and runs again, which exposes a counter that is not cleared on success or that fires off by one.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

    typedef enum logic [1:0] {
        OP_LOAD       = 2'd0,
        OP_LOCK_LOAD  = 2'd1,
        OP_STORE      = 2'd2,
        OP_COND_STORE = 2'd3
    } mem_op_e;

    typedef enum logic {
        RSV_IDLE = 1'b0,
        RSV_HELD = 1'b1
    } rsv_state_e;

    localparam logic [1:0] RES_FAIL = 2'd0;
    localparam logic [1:0] RES_PASS = 2'd1;
    localparam logic [1:0] RES_UNC  = 2'd2;

endpackage

// File: rtl/rsv_resolve.sv
module rsv_resolve
    import rsv_pkg::*;
#(
    parameter int NUM_THR  = 4,
    parameter int ADDR_W   = 32,
    parameter int GRAN_LSB = 4
) (
    input  logic [NUM_THR-1:0]        req_vld,
    input  logic [2*NUM_THR-1:0]      req_op,
    input  logic [ADDR_W*NUM_THR-1:0] req_addr,
    input  logic [NUM_THR-1:0]        req_unc,
    input  logic [NUM_THR-1:0]        cur_held,
    input  logic [ADDR_W*NUM_THR-1:0] cur_addr,
    output logic [NUM_THR-1:0]        nxt_held,
    output logic [ADDR_W*NUM_THR-1:0] nxt_addr,
    output logic [2*NUM_THR-1:0]      sc_result,
    output logic [NUM_THR-1:0]        mem_we,
    output logic [NUM_THR-1:0]        fail_inc,
    output logic [NUM_THR-1:0]        fail_clr
);

    localparam int GW = ADDR_W - GRAN_LSB;

    // Requests are folded into the working state one thread at a time,
    // lowest index first, so later threads see earlier updates.
    always_comb begin
        mem_op_e           op;
        logic [ADDR_W-1:0] a;
        logic              go;
        nxt_held  = cur_held;
        nxt_addr  = cur_addr;
        sc_result = '0;
        mem_we    = '0;
        fail_inc  = '0;
        fail_clr  = '0;
        for (int i = 0; i < NUM_THR; i++) begin
            op = mem_op_e'(req_op[2*i +: 2]);
            a  = req_addr[i*ADDR_W +: ADDR_W];
            go = 1'b0;
            if (req_vld[i]) begin
                unique case (op)
                    OP_LOAD: ;
                    OP_LOCK_LOAD: begin
                        nxt_held[i]                = 1'b1;
                        nxt_addr[i*ADDR_W +: ADDR_W] = a;
                    end
                    OP_STORE: go = 1'b1;
                    OP_COND_STORE: begin
                        if (req_unc[i]) begin
                            sc_result[2*i +: 2] = RES_UNC;
                            go                  = 1'b1;
                            fail_clr[i]         = 1'b1;
                        end else if (nxt_held[i] &&
                                     nxt_addr[i*ADDR_W+GRAN_LSB +: GW] == a[ADDR_W-1:GRAN_LSB]) begin
                            sc_result[2*i +: 2] = RES_PASS;
                            go                  = 1'b1;
                            fail_clr[i]         = 1'b1;
                        end else begin
                            sc_result[2*i +: 2] = RES_FAIL;
                            nxt_held[i]         = 1'b0;
                            fail_inc[i]         = 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
            if (go) begin
                mem_we[i] = 1'b1;
                for (int j = 0; j < NUM_THR; j++) begin
                    if (nxt_addr[j*ADDR_W+GRAN_LSB +: GW] == a[ADDR_W-1:GRAN_LSB])
                        nxt_held[j] = 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/rsv_fail_ctr.sv
module rsv_fail_ctr #(
    parameter int CNT_W        = 32,
    parameter int ALERT_PERIOD = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic clr,
    output logic alert
);

    localparam logic [CNT_W-1:0] PERIOD_V = CNT_W'(ALERT_PERIOD);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic             hit;

    assign cnt_inc = cnt_q + 1'b1;
    assign hit     = (cnt_inc % PERIOD_V) == '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            alert <= 1'b0;
        end else begin
            alert <= inc && hit;
            if (clr)
                cnt_q <= '0;
            else if (inc)
                cnt_q <= cnt_inc;
        end
    end

endmodule

// File: rtl/rsv_monitor.sv
module rsv_monitor
    import rsv_pkg::*;
#(
    parameter int NUM_THR      = 4,
    parameter int ADDR_W       = 32,
    parameter int GRAN_LSB     = 4,
    parameter int CNT_W        = 32,
    parameter int ALERT_PERIOD = 100000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_THR-1:0]        req_vld,
    input  logic [2*NUM_THR-1:0]      req_op,
    input  logic [ADDR_W*NUM_THR-1:0] req_addr,
    input  logic [NUM_THR-1:0]        req_unc,
    output logic [2*NUM_THR-1:0]      sc_result,
    output logic [NUM_THR-1:0]        mem_we,
    output logic [NUM_THR-1:0]        fail_alert
);

    rsv_state_e [NUM_THR-1:0]  state_q;
    logic [ADDR_W*NUM_THR-1:0] addr_q;
    logic [NUM_THR-1:0]        cur_held;
    logic [NUM_THR-1:0]        nxt_held;
    logic [ADDR_W*NUM_THR-1:0] nxt_addr;
    logic [NUM_THR-1:0]        fail_inc;
    logic [NUM_THR-1:0]        fail_clr;

    rsv_resolve #(
        .NUM_THR (NUM_THR),
        .ADDR_W  (ADDR_W),
        .GRAN_LSB(GRAN_LSB)
    ) u_resolve (
        .req_vld  (req_vld),
        .req_op   (req_op),
        .req_addr (req_addr),
        .req_unc  (req_unc),
        .cur_held (cur_held),
        .cur_addr (addr_q),
        .nxt_held (nxt_held),
        .nxt_addr (nxt_addr),
        .sc_result(sc_result),
        .mem_we   (mem_we),
        .fail_inc (fail_inc),
        .fail_clr (fail_clr)
    );

    for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
        // State register: LOCK, SNOOP, SC_MISS and RESET transitions.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                state_q[t]                   <= RSV_IDLE;
                addr_q[t*ADDR_W +: ADDR_W] <= '0;
            end else begin
                state_q[t]                   <= nxt_held[t] ? RSV_HELD : RSV_IDLE;
                addr_q[t*ADDR_W +: ADDR_W] <= nxt_addr[t*ADDR_W +: ADDR_W];
            end
        end

        // Output decode of the state.
        always_comb begin
            unique case (state_q[t])
                RSV_IDLE: cur_held[t] = 1'b0;
                RSV_HELD: cur_held[t] = 1'b1;
                default:  cur_held[t] = 1'b0;
            endcase
        end

        rsv_fail_ctr #(
            .CNT_W       (CNT_W),
            .ALERT_PERIOD(ALERT_PERIOD)
        ) u_fail_ctr (
            .clk  (clk),
            .rst_n(rst_n),
            .inc  (fail_inc[t]),
            .clr  (fail_clr[t]),
            .alert(fail_alert[t])
        );
    end

endmodule

// File: rtl/rsv_monitor_chk.sv
module rsv_monitor_chk #(
    parameter int NUM_THR = 4,
    parameter int ADDR_W  = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NUM_THR-1:0]        req_vld,
    input logic [2*NUM_THR-1:0]      req_op,
    input logic [NUM_THR-1:0]        req_unc,
    input logic [2*NUM_THR-1:0]      sc_result,
    input logic [NUM_THR-1:0]        mem_we,
    input logic [NUM_THR-1:0]        fail_alert
);

    for (genvar t = 0; t < NUM_THR; t++) begin : g_chk
        logic is_sc;
        logic is_ld;
        assign is_sc = req_vld[t] && req_op[2*t +: 2] == 2'd3;
        assign is_ld = req_vld[t] && req_op[2*t +: 2] <= 2'd1;

        assert_pass_writes_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (is_sc && !req_unc[t] && sc_result[2*t +: 2] == 2'd1) |-> mem_we[t]);

        assert_fail_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (is_sc && sc_result[2*t +: 2] == 2'd0) |-> !mem_we[t]);

        assert_unc_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (is_sc && req_unc[t]) |-> (sc_result[2*t +: 2] == 2'd2 && mem_we[t]));

        assert_no_code3_R5: assert property (@(posedge clk) disable iff (!rst_n)
            sc_result[2*t +: 2] != 2'd3);

        assert_load_inert_R7: assert property (@(posedge clk) disable iff (!rst_n)
            is_ld |-> (!mem_we[t] && sc_result[2*t +: 2] == 2'd0));

        assert_alert_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
            fail_alert[t] |-> $past(is_sc && !req_unc[t] && sc_result[2*t +: 2] == 2'd0));
    end

endmodule

bind rsv_monitor rsv_monitor_chk #(
    .NUM_THR(NUM_THR),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_vld   (req_vld),
    .req_op    (req_op),
    .req_unc   (req_unc),
    .sc_result (sc_result),
    .mem_we    (mem_we),
    .fail_alert(fail_alert)
);

// File: tb/rsv_monitor_tb.sv
module rsv_monitor_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NT  = 4;
    localparam int AW  = 32;
    localparam int PER = 3;

    localparam logic [1:0] LD = 2'd0, LL = 2'd1, ST = 2'd2, SC = 2'd3;

    typedef struct {
        int         thr;
        logic [1:0] res;
        logic       we;
        string      tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NT-1:0]     req_vld = '0;
    logic [2*NT-1:0]   req_op = '0;
    logic [AW*NT-1:0]  req_addr = '0;
    logic [NT-1:0]     req_unc = '0;
    logic [2*NT-1:0]   sc_result;
    logic [NT-1:0]     mem_we;
    logic [NT-1:0]     fail_alert;

    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;
    exp_t exp_q[$];
    event mon_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    rsv_monitor #(
        .NUM_THR(NT), .ADDR_W(AW), .GRAN_LSB(4), .CNT_W(32), .ALERT_PERIOD(PER)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_op(req_op),
        .req_addr(req_addr), .req_unc(req_unc), .sc_result(sc_result),
        .mem_we(mem_we), .fail_alert(fail_alert)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic begin_cycle();
        @(negedge clk);
        req_vld = '0;
        req_unc = '0;
    endtask

    task automatic stage(int t, logic [1:0] op, logic [31:0] a, logic unc,
                         logic [1:0] eres, logic ewe, string tag);
        exp_t e;
        req_vld[t]           = 1'b1;
        req_op[2*t +: 2]     = op;
        req_addr[t*AW +: AW] = a;
        req_unc[t]           = unc;
        e.thr = t; e.res = eres; e.we = ewe; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic end_cycle();
        -> mon_ev;
        @(posedge clk);
    endtask

    task automatic one(int t, logic [1:0] op, logic [31:0] a, logic unc,
                       logic [1:0] eres, logic ewe, string tag);
        begin_cycle();
        stage(t, op, a, unc, eres, ewe, tag);
        end_cycle();
    endtask

    // Scoreboard monitor: outputs are combinational, sample 1 unit after drive.
    always begin
        @(mon_ev);
        #1;
        while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check({e.tag, " result"}, 32'(sc_result[2*e.thr +: 2]), 32'(e.res));
            check({e.tag, " mem_we"}, 32'(mem_we[e.thr]), 32'(e.we));
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10: quiet after reset
        check("R10 alert after reset", 32'(fail_alert), 0);
        check("R10 mem_we idle", 32'(mem_we), 0);
        one(0, SC, 32'h100, 0, 2'd0, 0, "R10 no reservation after reset");

        // R1 / R2 / R4
        one(0, LL, 32'h100, 0, 2'd0, 0, "R1 locked load");
        one(0, SC, 32'h104, 0, 2'd1, 1, "R1 R2 same granule pass");
        one(0, SC, 32'h100, 0, 2'd0, 0, "R4 reservation consumed");

        // R2 / R3
        one(1, LL, 32'h200, 0, 2'd0, 0, "R2 locked load");
        one(1, SC, 32'h210, 0, 2'd0, 0, "R2 next granule fails");
        one(1, SC, 32'h200, 0, 2'd0, 0, "R3 cleared by failure");

        // R5
        one(2, SC, 32'h300, 1, 2'd2, 1, "R5 uncacheable without reservation");

        // R6: plain store clears every matching thread
        one(0, LL, 32'h400, 0, 2'd0, 0, "R6 lock t0");
        one(1, LL, 32'h408, 0, 2'd0, 0, "R6 lock t1");
        one(3, ST, 32'h40C, 0, 2'd0, 1, "R6 plain store");
        one(0, SC, 32'h400, 0, 2'd0, 0, "R6 t0 snooped");
        one(1, SC, 32'h408, 0, 2'd0, 0, "R6 t1 snooped");
        // failing SC leaves others; passing SC clears others
        one(0, LL, 32'h500, 0, 2'd0, 0, "R6 lock t0");
        one(1, LL, 32'h500, 0, 2'd0, 0, "R6 lock t1");
        one(2, SC, 32'h500, 0, 2'd0, 0, "R6 t2 fails");
        one(0, SC, 32'h500, 0, 2'd1, 1, "R6 t0 survives failing SC");
        one(1, SC, 32'h500, 0, 2'd0, 0, "R6 t1 cleared by passing SC");
        // uncacheable SC clears
        one(3, LL, 32'h600, 0, 2'd0, 0, "R6 lock t3");
        one(2, SC, 32'h608, 1, 2'd2, 1, "R6 uncacheable store");
        one(3, SC, 32'h600, 0, 2'd0, 0, "R6 t3 cleared by uncacheable SC");

        // R7
        one(0, LL, 32'h700, 0, 2'd0, 0, "R7 lock t0");
        one(1, LD, 32'h700, 0, 2'd0, 0, "R7 plain load other thread");
        one(0, LD, 32'h700, 0, 2'd0, 0, "R7 plain load own thread");
        one(0, SC, 32'h700, 0, 2'd1, 1, "R7 reservation kept");

        // R8: same-cycle ordering
        one(0, LL, 32'h800, 0, 2'd0, 0, "R8 lock t0");
        begin_cycle();
        stage(0, SC, 32'h800, 0, 2'd1, 1, "R8 t0 pass first");
        stage(1, LL, 32'h800, 0, 2'd0, 0, "R8 t1 lock after");
        end_cycle();
        one(1, SC, 32'h800, 0, 2'd1, 1, "R8 t1 lock survived");
        one(1, LL, 32'h900, 0, 2'd0, 0, "R8 lock t1");
        begin_cycle();
        stage(0, ST, 32'h900, 0, 2'd0, 1, "R8 t0 store first");
        stage(1, SC, 32'h900, 0, 2'd0, 0, "R8 t1 sees store");
        end_cycle();
        begin_cycle();
        stage(0, ST, 32'hB00, 0, 2'd0, 1, "R8 store before lock");
        stage(1, LL, 32'hB04, 0, 2'd0, 0, "R8 lock after store");
        end_cycle();
        one(1, SC, 32'hB00, 0, 2'd1, 1, "R8 later lock kept");

        // R9: alert on thread 2, period 3
        one(2, SC, 32'hD00, 1, 2'd2, 1, "R9 reset count");
        one(2, SC, 32'hD00, 0, 2'd0, 0, "R9 fail 1");
        #1 check("R9 no alert at 1", 32'(fail_alert[2]), 0);
        one(2, SC, 32'hD00, 0, 2'd0, 0, "R9 fail 2");
        #1 check("R9 no alert at 2", 32'(fail_alert[2]), 0);
        one(2, SC, 32'hD00, 0, 2'd0, 0, "R9 fail 3");
        #1 check("R9 alert at 3", 32'(fail_alert[2]), 1);
        @(posedge clk);
        #1 check("R9 alert one cycle", 32'(fail_alert[2]), 0);
        one(2, SC, 32'hD00, 0, 2'd0, 0, "R9 fail 4");
        one(2, SC, 32'hD00, 0, 2'd0, 0, "R9 fail 5");
        one(2, SC, 32'hD00, 1, 2'd2, 1, "R9 uncacheable resets");
        one(2, SC, 32'hD00, 0, 2'd0, 0, "R9 fail 1 again");
        one(2, SC, 32'hD00, 0, 2'd0, 0, "R9 fail 2 again");
        #1 check("R9 no alert after reset count", 32'(fail_alert[2]), 0);
        one(2, SC, 32'hD00, 0, 2'd0, 0, "R9 fail 3 again");
        #1 check("R9 alert after reset count", 32'(fail_alert[2]), 1);

        // R10: reset mid-run drops a reservation
        one(1, LL, 32'hC00, 0, 2'd0, 0, "R10 lock t1");
        begin_cycle();
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        one(1, SC, 32'hC00, 0, 2'd0, 0, "R10 reservation dropped by reset");

        begin_cycle();
        #2;
        finish_run();
    end

endmodule